// File: doc/BRIEF.md
# Priority-Sorted Pending Request Queue Pair

This block holds the pending cache requests of two load/store pipelines in two fixed-capacity queues. Each queue is kept sorted by a small priority number, and a smaller number means more urgent. An issuing execution slot offers a request on a valid/ready insert stream. A steering stage picks the target queue from the slot code. The request carries an id, a kind code and a priority, and it is placed into the queue behind every entry of equal or more urgent priority. Each queue shows its most urgent entry on a plain head port.

Requests are not taken from the head automatically. A separate remove port names a queue and an id, and the matching entry is taken out wherever it sits. The entries around it close up. Every queue owns a pool of storage slots, and a free list hands these out. A removed entry gives its slot back at once, so the pool can be filled and drained again any number of times.

Back-pressure rules: `in_ready` depends only on the slot code and on the occupancy of the selected queue at the start of the cycle. It never depends on a remove in the same cycle. A transfer happens on a rising edge where both `in_valid` and `in_ready` are high. A request with an illegal slot code is always accepted and then discarded.

Top module: `req_prio_queue`

## Requirements
- R1: Slot code 0 (integer slot 0) and code 2 (the coprocessor unit) steer to queue 0 (LS). Code 1 (integer slot 1) steers to queue 1 (LD).
- R2: Slot code 3 is illegal. Such a request sees `in_ready` high and is stored in no queue, and `slot_err` is high in the following cycle only.
- R3: When a queue is not empty, its head outputs show the id, kind and priority of its entry with the numerically smallest priority. Any change made at a clock edge is visible on the head outputs right after that edge.
- R4: An inserted entry is placed behind every entry whose priority value is less than or equal to its own, and ahead of the first entry with a strictly greater value. Entries of equal priority therefore leave in arrival order.
- R5: A remove with `rm_q` selecting a queue deletes the entry nearest the head whose id equals `rm_id`. This entry may sit at the head, in the middle or at the tail, and the remaining entries keep their relative order.
- R6: A remove whose id is not present in the selected queue changes nothing, and `rm_err` is high in the following cycle only.
- R7: Each queue holds at most DEPTH (16) entries. When the selected queue is full, `in_ready` is low, the offered request is not stored and `q_full` of that queue is high.
- R8: A removed entry frees its storage slot. A queue that was filled and then drained accepts DEPTH new entries again.
- R9: An insert and a remove in the same cycle are both carried out. The remove is applied first, and the insert position is computed among the remaining entries. A queue that is full at the start of the cycle still refuses the insert.
- R10: After reset both queues are empty, `q_full` is low and both error flags are low.
- R11: `hd_valid` of a queue is high exactly when the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Insert request offered |
| in_ready | output | 1 | Insert request can be taken this cycle |
| in_slot | input | 2 | Issuing slot code: 0 int slot 0, 1 int slot 1, 2 coprocessor, 3 illegal |
| in_id | input | ID_W | Request id |
| in_kind | input | 3 | Kind: 0 load, 1 store, 2 preload, 3 invalidate, 4 unlock |
| in_prio | input | PRIO_W | Priority value, 0 most urgent |
| rm_en | input | 1 | Remove request this cycle |
| rm_q | input | 1 | Queue of the remove: 0 LS, 1 LD |
| rm_id | input | ID_W | Id to remove |
| hd_valid | output | 2 | Per queue: head entry present |
| hd_id | output | 2 x ID_W | Per queue: head id |
| hd_kind | output | 2 x 3 | Per queue: head kind |
| hd_prio | output | 2 x PRIO_W | Per queue: head priority |
| q_full | output | 2 | Per queue: all slots in use |
| rm_err | output | 1 | Previous remove found no matching id |
| slot_err | output | 1 | Previous insert carried an illegal slot code |

## Verification
The hardest situation to reach from the ports is a full queue that gets an insert and a remove in the same cycle, where duplicate ids and tied priorities decide which entry leaves and where the refused request would have gone. A directed phase fills queue 0 beyond its capacity and then issues the combined insert and remove. A long random phase follows with a small id range, few priority levels and inserts more frequent than removes, so both queues keep coming back to full with many repeated ids and ties. A behavioural list model is compared against every output in every cycle.

// File: rtl/rq_pkg.sv
package rq_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    RK_LOAD    = 3'd0,
    RK_STORE   = 3'd1,
    RK_PRELOAD = 3'd2,
    RK_INVAL   = 3'd3,
    RK_UNLOCK  = 3'd4
  } rq_kind_e;

  typedef enum logic [1:0] {
    SLOT_INT0 = 2'd0,
    SLOT_INT1 = 2'd1,
    SLOT_COP  = 2'd2,
    SLOT_BAD  = 2'd3
  } rq_slot_e;

  localparam int Q_LS = 0;
  localparam int Q_LD = 1;
  localparam int NQ   = 2;

endpackage

// File: rtl/rq_steer.sv
module rq_steer
  import rq_pkg::*;
(
  input  logic [1:0] slot,
  output logic       legal,
  output logic       qsel
);

  always_comb begin
    legal = 1'b1;
    qsel  = 1'b0;
    case (rq_slot_e'(slot))
      SLOT_INT0: qsel = 1'(Q_LS);
      SLOT_COP:  qsel = 1'(Q_LS);
      SLOT_INT1: qsel = 1'(Q_LD);
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/rq_freelist.sv
module rq_freelist #(
  parameter int DEPTH = 16,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          free_en,
  input  logic [SW-1:0] free_idx,
  output logic [SW-1:0] alloc_idx
);

  logic [DEPTH-1:0] avail;

  always_comb begin
    alloc_idx = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (avail[s]) alloc_idx = SW'(s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail <= '1;
    end else begin
      if (free_en)  avail[free_idx]  <= 1'b1;
      if (alloc_en) avail[alloc_idx] <= 1'b0;
    end
  end

endmodule

// File: rtl/rq_core.sv
module rq_core #(
  parameter int DEPTH  = 16,
  parameter int ID_W   = 6,
  parameter int PRIO_W = 3,
  parameter int KIND_W = 3,
  localparam int SW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [ID_W-1:0]   ins_id,
  input  logic [KIND_W-1:0] ins_kind,
  input  logic [PRIO_W-1:0] ins_prio,
  input  logic              rm_en,
  input  logic [ID_W-1:0]   rm_id,
  output logic              full,
  output logic              hd_valid,
  output logic [ID_W-1:0]   hd_id,
  output logic [KIND_W-1:0] hd_kind,
  output logic [PRIO_W-1:0] hd_prio,
  output logic              rm_err
);

  // per-slot payload, not reset: only read through the order list
  logic [ID_W-1:0]   slot_id   [DEPTH];
  logic [KIND_W-1:0] slot_kind [DEPTH];
  logic [PRIO_W-1:0] slot_prio [DEPTH];

  // order list: position 0 is the head
  logic [SW-1:0] ord   [DEPTH];
  logic [SW-1:0] ord_a [DEPTH];
  logic [SW-1:0] ord_n [DEPTH];
  logic [CW-1:0] cnt, cnt_a, cnt_n;

  logic          rm_found, do_rm, do_ins;
  logic [SW-1:0] rm_pos, new_slot;
  logic [CW-1:0] ins_pos;

  assign full   = (cnt == CW'(DEPTH));
  assign do_ins = ins_en && !full;

  // locate the entry nearest the head carrying rm_id
  always_comb begin
    rm_found = 1'b0;
    rm_pos   = '0;
    for (int p = DEPTH - 1; p >= 0; p--) begin
      if (p < int'(cnt) && slot_id[ord[p]] == rm_id) begin
        rm_found = 1'b1;
        rm_pos   = SW'(p);
      end
    end
  end

  assign do_rm = rm_en && rm_found;
  assign cnt_a = cnt - CW'(do_rm);

  // stage 1: close the gap left by the removed entry
  for (genvar g = 0; g < DEPTH; g++) begin : gen_close
    if (g < DEPTH - 1) begin : gen_mid
      assign ord_a[g] = (do_rm && g >= int'(rm_pos)) ? ord[g+1] : ord[g];
    end else begin : gen_last
      assign ord_a[g] = ord[g];
    end
  end

  // stage 2: the insert lands behind every entry of equal or smaller value
  always_comb begin
    ins_pos = '0;
    for (int p = 0; p < DEPTH; p++) begin
      if (p < int'(cnt_a) && slot_prio[ord_a[p]] <= ins_prio)
        ins_pos = ins_pos + CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gen_open
    if (g > 0) begin : gen_shift
      always_comb begin
        if (!do_ins || g < int'(ins_pos))   ord_n[g] = ord_a[g];
        else if (g == int'(ins_pos))        ord_n[g] = new_slot;
        else                                ord_n[g] = ord_a[g-1];
      end
    end else begin : gen_head
      always_comb begin
        if (do_ins && ins_pos == '0) ord_n[g] = new_slot;
        else                         ord_n[g] = ord_a[g];
      end
    end
  end

  assign cnt_n = cnt_a + CW'(do_ins);

  rq_freelist #(.DEPTH(DEPTH)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (do_ins),
    .free_en   (do_rm),
    .free_idx  (ord[rm_pos]),
    .alloc_idx (new_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rm_err <= 1'b0;
      for (int p = 0; p < DEPTH; p++) ord[p] <= '0;
    end else begin
      cnt    <= cnt_n;
      rm_err <= rm_en && !rm_found;
      for (int p = 0; p < DEPTH; p++) ord[p] <= ord_n[p];
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      slot_id[new_slot]   <= ins_id;
      slot_kind[new_slot] <= ins_kind;
      slot_prio[new_slot] <= ins_prio;
    end
  end

  assign hd_valid = (cnt != '0);
  assign hd_id    = slot_id[ord[0]];
  assign hd_kind  = slot_kind[ord[0]];
  assign hd_prio  = slot_prio[ord[0]];

endmodule

// File: rtl/req_prio_queue.sv
module req_prio_queue
  import rq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ID_W   = 6,
  parameter int PRIO_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [1:0]                   in_slot,
  input  logic [ID_W-1:0]              in_id,
  input  logic [KIND_W-1:0]            in_kind,
  input  logic [PRIO_W-1:0]            in_prio,
  input  logic                         rm_en,
  input  logic                         rm_q,
  input  logic [ID_W-1:0]              rm_id,
  output logic [NQ-1:0]                hd_valid,
  output logic [NQ-1:0][ID_W-1:0]      hd_id,
  output logic [NQ-1:0][KIND_W-1:0]    hd_kind,
  output logic [NQ-1:0][PRIO_W-1:0]    hd_prio,
  output logic [NQ-1:0]                q_full,
  output logic                         rm_err,
  output logic                         slot_err
);

  logic          legal, qsel;
  logic [NQ-1:0] miss;

  rq_steer u_steer (
    .slot  (in_slot),
    .legal (legal),
    .qsel  (qsel)
  );

  assign in_ready = !legal || !q_full[qsel];

  for (genvar q = 0; q < NQ; q++) begin : gen_q
    rq_core #(
      .DEPTH  (DEPTH),
      .ID_W   (ID_W),
      .PRIO_W (PRIO_W),
      .KIND_W (KIND_W)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (in_valid && legal && (qsel == 1'(q))),
      .ins_id   (in_id),
      .ins_kind (in_kind),
      .ins_prio (in_prio),
      .rm_en    (rm_en && (rm_q == 1'(q))),
      .rm_id    (rm_id),
      .full     (q_full[q]),
      .hd_valid (hd_valid[q]),
      .hd_id    (hd_id[q]),
      .hd_kind  (hd_kind[q]),
      .hd_prio  (hd_prio[q]),
      .rm_err   (miss[q])
    );
  end

  assign rm_err = |miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_err <= 1'b0;
    else        slot_err <= in_valid && !legal;
  end

endmodule

// File: rtl/rq_chk.sv
module rq_chk #(
  parameter int ID_W   = 6,
  parameter int PRIO_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [1:0]             in_slot,
  input logic                   rm_en,
  input logic [1:0]             hd_valid,
  input logic [1:0][ID_W-1:0]   hd_id,
  input logic [1:0]             q_full,
  input logic                   rm_err,
  input logic                   slot_err
);

  logic tgt_q;
  assign tgt_q = (in_slot == 2'd1);

  a_r7_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_slot != 2'd3 && q_full[tgt_q]) |-> !in_ready);

  a_r2_bad_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_slot == 2'd3) |-> in_ready);

  a_r2_bad_slot_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_slot == 2'd3) |=> slot_err);

  a_r6_err_follows_remove: assert property (@(posedge clk) disable iff (!rst_n)
    rm_err |-> $past(rm_en));

  a_r3_head_steady_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !rm_en) |=> ($stable(hd_valid) && $stable(hd_id)));

  for (genvar q = 0; q < 2; q++) begin : gen_qchk
    a_r11_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
      q_full[q] |-> hd_valid[q]);
  end

endmodule

bind req_prio_queue rq_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_slot  (in_slot),
  .rm_en    (rm_en),
  .hd_valid (hd_valid),
  .hd_id    (hd_id),
  .q_full   (q_full),
  .rm_err   (rm_err),
  .slot_err (slot_err)
);

// File: tb/req_prio_queue_tb.sv
`timescale 1ns/1ps
module req_prio_queue_tb;

  localparam int DEPTH  = 16;
  localparam int ID_W   = 6;
  localparam int PRIO_W = 3;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [1:0]              in_slot = '0;
  logic [ID_W-1:0]         in_id = '0;
  logic [2:0]              in_kind = '0;
  logic [PRIO_W-1:0]       in_prio = '0;
  logic                    rm_en = 1'b0;
  logic                    rm_q = 1'b0;
  logic [ID_W-1:0]         rm_id = '0;
  logic [1:0]              hd_valid;
  logic [1:0][ID_W-1:0]    hd_id;
  logic [1:0][2:0]         hd_kind;
  logic [1:0][PRIO_W-1:0]  hd_prio;
  logic [1:0]              q_full;
  logic                    rm_err;
  logic                    slot_err;

  always #5 clk = ~clk;

  req_prio_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot(in_slot), .in_id(in_id), .in_kind(in_kind), .in_prio(in_prio),
    .rm_en(rm_en), .rm_q(rm_q), .rm_id(rm_id), .hd_valid(hd_valid),
    .hd_id(hd_id), .hd_kind(hd_kind), .hd_prio(hd_prio), .q_full(q_full),
    .rm_err(rm_err), .slot_err(slot_err)
  );

  // reference model: one list, each entry tagged with its queue
  typedef struct { int q; int id; int kind; int prio; } ent_t;
  ent_t  model[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    exp_rm_err = 1'b0;
  bit    exp_slot_err = 1'b0;
  bit    done = 1'b0;
  string tag = "R10";

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_count(int q);
    int n = 0;
    foreach (model[i]) if (model[i].q == q) n++;
    return n;
  endfunction

  function automatic int m_head_idx(int q);
    foreach (model[i]) if (model[i].q == q) return i;
    return -1;
  endfunction

  task automatic compare_all();
    for (int q = 0; q < 2; q++) begin
      int h = m_head_idx(q);
      chk("R11 head_valid", int'(hd_valid[q]), int'(h >= 0));
      if (h >= 0) begin
        chk("R3 R4 R5 head_id", int'(hd_id[q]), model[h].id);
        chk("R3 head_kind", int'(hd_kind[q]), model[h].kind);
        chk("R3 head_prio", int'(hd_prio[q]), model[h].prio);
      end
      chk("R7 q_full", int'(q_full[q]), int'(m_count(q) == DEPTH));
    end
    chk("R6 rm_err", int'(rm_err), int'(exp_rm_err));
    chk("R2 slot_err", int'(slot_err), int'(exp_slot_err));
  endtask

  task automatic cyc(bit iv, int slot, int id, int kind, int prio,
                     bit re, int rq, int rid);
    bit legal, rdy, found;
    int qs, pos;
    ent_t e;
    @(negedge clk);
    compare_all();
    in_valid = iv; in_slot = 2'(slot); in_id = ID_W'(id);
    in_kind = 3'(kind); in_prio = PRIO_W'(prio);
    rm_en = re; rm_q = 1'(rq); rm_id = ID_W'(rid);
    #1;
    legal = (slot != 3);
    qs    = (slot == 1) ? 1 : 0;
    rdy   = legal ? (m_count(qs) < DEPTH) : 1'b1;
    if (iv) chk("R7 R9 in_ready", int'(in_ready), int'(rdy));
    found = 1'b0;
    if (re) begin
      foreach (model[i]) begin
        if (!found && model[i].q == rq && model[i].id == rid) begin
          found = 1'b1;
          pos = i;
        end
      end
      if (found) model.delete(pos);
    end
    exp_rm_err = re && !found;
    if (iv && legal && rdy) begin
      e.q = qs; e.id = id; e.kind = kind; e.prio = prio;
      pos = model.size();
      for (int i = model.size() - 1; i >= 0; i--)
        if (model[i].q == qs && model[i].prio > prio) pos = i;
      model.insert(pos, e);
    end
    exp_slot_err = iv && !legal;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(int q);
    for (int k = 0; k < DEPTH + 2; k++) begin
      int h = m_head_idx(q);
      if (h >= 0) cyc(0, 0, 0, 0, 0, 1, q, model[h].id);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tag = "R10"; idle();

    tag = "R1";
    cyc(1, 0, 1, 0, 3, 0, 0, 0);
    cyc(1, 2, 2, 1, 3, 0, 0, 0);
    cyc(1, 1, 3, 2, 1, 0, 0, 0);
    idle();

    tag = "R2";
    cyc(1, 3, 9, 0, 0, 0, 0, 0);
    idle();

    tag = "R4";
    cyc(1, 0, 10, 1, 5, 0, 0, 0);
    cyc(1, 0, 11, 2, 2, 0, 0, 0);
    cyc(1, 2, 12, 3, 5, 0, 0, 0);
    cyc(1, 0, 13, 4, 2, 0, 0, 0);
    cyc(1, 0, 14, 0, 7, 0, 0, 0);
    cyc(1, 0, 15, 1, 0, 0, 0, 0);
    cyc(1, 2, 16, 4, 3, 0, 0, 0);
    idle();

    tag = "R5";
    cyc(0, 0, 0, 0, 0, 1, 0, 12);
    cyc(0, 0, 0, 0, 0, 1, 0, 15);
    cyc(0, 0, 0, 0, 0, 1, 0, 14);
    cyc(0, 0, 0, 0, 0, 1, 0, 1);
    idle();

    tag = "R6";
    cyc(0, 0, 0, 0, 0, 1, 0, 40);
    cyc(0, 0, 0, 0, 0, 1, 1, 2);
    idle();

    tag = "R9";
    cyc(1, 0, 20, 2, 2, 1, 0, 11);
    cyc(1, 0, 21, 3, 0, 1, 1, 3);
    idle();

    tag = "R7";
    for (int i = 0; i < DEPTH + 4; i++) cyc(1, 0, 30 + i, i % 5, i % 4, 0, 0, 0);
    idle();
    cyc(1, 2, 60, 1, 0, 1, 0, 31);
    idle();

    tag = "R8";
    drain(0);
    idle();
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 2, i, 2, 3 - (i % 4), 0, 0, 0);
    idle();
    drain(0);
    drain(1);
    idle();

    tag = "R3";
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 4) != 0, $urandom % 4, $urandom % 16, $urandom % 5,
          $urandom % 4, ($urandom % 3) == 0, $urandom % 2, $urandom % 16);
    end
    idle();
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule